// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block produces a periodic timer interrupt. An internal prescaler divides the reference clock into a one-millisecond enable. A period counter counts those milliseconds and expires once every (reload+1) of them. On each expiry the counter re-arms for the next period without any software action, and the interrupt flag is set. The flag is a level. It stays high until software acknowledges it.

Software has two strobes. A reload write stores a new period value, restarts the prescaler and the period counter from zero, and clears the flag. A count read also clears the flag and returns zero, because no live count is kept. If an expiry and an acknowledge fall in the same cycle, the expiry wins and the flag stays set. Both strobes are single-cycle controls with no handshake, so there is no back-pressure at this block's edge. Every strobe is accepted in the cycle it is high.

Top module: `interval_tick_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `irq` is low and the stored reload value is 0, so the first period after reset lasts CLKS_PER_MS reference clocks.
- R2: With reload value r, an expiry occurs on the clock edge that ends reference cycle number (r+1)*CLKS_PER_MS, counted from the restart. `irq` is high in the cycle after that edge.
- R3: After an expiry the timer re-arms by itself. The next expiry follows a further (r+1)*CLKS_PER_MS cycles, with no software action.
- R4: A cycle with `reload_wr` high stores `reload_data` as r. It restarts the period from zero at that edge and clears `irq` on that edge, unless R7 applies.
- R5: A cycle with `count_rd` high clears `irq` on that edge, unless R7 applies. It does not change the period timing.
- R6: `count_rdata` is zero in every cycle, including the cycles in which `count_rd` is high.
- R7: If an expiry and a reload write or count read occur in the same cycle, `irq` is high after that edge. A reload write in that cycle still restarts the period with the new value.
- R8: Once set, `irq` stays high until a reload write or a count read occurs.
- R9: Every reload value up to the all-ones value of RELOAD_W bits gives a period of (r+1) milliseconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_wr | input | 1 | Strobe: store reload value, restart, acknowledge |
| reload_data | input | RELOAD_W | Period in milliseconds minus one |
| count_rd | input | 1 | Strobe: count register read, acknowledge |
| count_rdata | output | DATA_W | Count register read data, always zero |
| irq | output | 1 | Timer interrupt level |

## Verification
An expiry can coincide with an acknowledge: either a count read or a reload write. The bench provokes each case. It waits for a rising `irq` and then places the strobe exactly (r+1)*CLKS_PER_MS cycles after that expiry. The behavioural model computes the expected flag, with the expiry taking priority. `irq` is then checked to still be high, and after a write it is also checked that the next period uses the new value.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // What the interrupt flag does on one clock edge
  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

  function automatic flag_op_e flag_decide(input logic expire, input logic ack);
    if (expire)   return FLAG_SET;
    else if (ack) return FLAG_CLEAR;
    else          return FLAG_HOLD;
  endfunction
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int CLKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ms_tick
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

  generate
    if (CLKS_PER_MS == 1) begin : g_pass
      assign ms_tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign ms_tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pit_period.sv
module pit_period #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_tick,
  input  logic                load,
  input  logic [RELOAD_W-1:0] load_val,
  output logic                expire
);
  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] ms_q;

  assign expire = ms_tick && (ms_q == reload_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ms_q     <= '0;
    end else if (load) begin
      reload_q <= load_val;
      ms_q     <= '0;
    end else if (expire) begin
      ms_q     <= '0;
    end else if (ms_tick) begin
      ms_q     <= ms_q + 1'b1;
    end
  end
endmodule

// File: rtl/pit_flag.sv
module pit_flag
  import pit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  output logic flag
);
  flag_op_e op;
  assign op = flag_decide(expire, ack);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else begin
      unique case (op)
        FLAG_SET:   flag <= 1'b1;
        FLAG_CLEAR: flag <= 1'b0;
        default:    flag <= flag;
      endcase
    end
  end
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int CLKS_PER_MS = 1000,
  parameter int RELOAD_W    = 16,
  parameter int DATA_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reload_wr,
  input  logic [RELOAD_W-1:0] reload_data,
  input  logic                count_rd,
  output logic [DATA_W-1:0]   count_rdata,
  output logic                irq
);
  logic ms_tick_w;
  logic expire_w;
  logic ack_w;

  assign ack_w       = reload_wr | count_rd;
  assign count_rdata = '0;

  pit_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (reload_wr),
    .ms_tick (ms_tick_w)
  );

  pit_period #(.RELOAD_W(RELOAD_W)) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick_w),
    .load     (reload_wr),
    .load_val (reload_data),
    .expire   (expire_w)
  );

  pit_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire_w),
    .ack    (ack_w),
    .flag   (irq)
  );
endmodule

// File: rtl/interval_tick_timer_chk.sv
module interval_tick_timer_chk #(
  parameter int CLKS_PER_MS = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic reload_wr,
  input logic count_rd,
  input logic ms_tick,
  input logic expire,
  input logic irq
);
  // R2: an expiry raises the flag on the next cycle
  assert_expire_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  // R7: expiry together with an acknowledge still leaves the flag set
  assert_expire_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (reload_wr || count_rd)) |=> irq);

  // R4 / R5: an acknowledge without an expiry clears the flag
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reload_wr || count_rd) && !expire) |=> !irq);

  // R8: the flag holds while there is no acknowledge
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reload_wr && !count_rd) |=> irq);

  // R3: the flag only rises after an expiry
  assert_rise_from_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire));

  // R4: a reload write restarts the millisecond prescaler
  assert_restart_prescaler_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && (CLKS_PER_MS > 1)) |=> !ms_tick);
endmodule

bind interval_tick_timer interval_tick_timer_chk #(.CLKS_PER_MS(CLKS_PER_MS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reload_wr (reload_wr),
  .count_rd  (count_rd),
  .ms_tick   (ms_tick_w),
  .expire    (expire_w),
  .irq       (irq)
);

// File: tb/interval_tick_timer_bench.sv
module interval_tick_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int RW  = 4;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reload_wr = 1'b0;
  logic [RW-1:0] reload_data = '0;
  logic          count_rd = 1'b0;
  logic [DW-1:0] count_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit chk_en = 1'b0;

  // reference model state
  int m_elapsed = 0;
  int m_reload  = 0;
  bit m_irq     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_tick_timer #(.CLKS_PER_MS(N), .RELOAD_W(RW), .DATA_W(DW)) u_interval_tick_timer (
    .clk(clk), .rst_n(rst_n), .reload_wr(reload_wr), .reload_data(reload_data),
    .count_rd(count_rd), .count_rdata(count_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    bit exp_now;
    if (!rst_n) begin
      m_elapsed = 0; m_reload = 0; m_irq = 1'b0;
    end else begin
      exp_now = (m_elapsed == (m_reload + 1) * N - 1);
      if (exp_now) m_irq = 1'b1;
      else if (reload_wr || count_rd) m_irq = 1'b0;
      if (reload_wr) begin
        m_reload = int'(reload_data); m_elapsed = 0;
      end else if (exp_now) m_elapsed = 0;
      else m_elapsed = m_elapsed + 1;
    end
    chk_en = 1'b1;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(tag, {31'd0, irq}, {31'd0, m_irq});
      check("R6", count_rdata, '0);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      reload_wr = 1'b0; count_rd = 1'b0;
    end
  endtask

  task automatic do_write(input int v);
    @(negedge clk); #1;
    reload_wr = 1'b1; reload_data = RW'(v); count_rd = 1'b0;
    @(negedge clk); #1;
    reload_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); #1;
    count_rd = 1'b1;
    @(negedge clk); #1;
    count_rd = 1'b0;
  endtask

  task automatic wait_irq();
    int guard = 0;
    while (irq !== 1'b1 && guard < 1000) begin
      @(negedge clk); guard++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", {31'd0, irq}, '0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, irq}, '0);
    tag = "R2";
    idle(N + 4);
    check("R2", {31'd0, irq}, 32'd1);
    tag = "R8";
    idle(20);
    check("R8", {31'd0, irq}, 32'd1);
    tag = "R5";
    @(negedge clk); #1 count_rd = 1'b1;
    @(negedge clk);
    check("R6", count_rdata, '0);
    #1 count_rd = 1'b0;
    tag = "R3";
    idle(12);
    tag = "R4";
    do_write(2);
    idle(40);
    tag = "R9";
    do_write(15);
    idle(150);
    check("R9", {31'd0, irq}, 32'd1);
    tag = "R7";
    do_write(1);
    wait_irq();
    // count read lands exactly on the next expiry
    repeat (2 * N - 1) @(negedge clk);
    #1 count_rd = 1'b1;
    @(negedge clk);
    check("R7", {31'd0, irq}, 32'd1);
    #1 count_rd = 1'b0;
    // reload write lands exactly on the following expiry
    repeat (2 * N - 1) @(negedge clk);
    #1 reload_wr = 1'b1; reload_data = RW'(3);
    @(negedge clk);
    check("R7", {31'd0, irq}, 32'd1);
    #1 reload_wr = 1'b0;
    do_read();
    idle(4 * N + 6);
    check("R4", {31'd0, irq}, 32'd1);
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule